// File: doc/BRIEF.md
# Prioritized Interrupt Level Controller

This block collects interrupt requests arranged as numbered priority levels. Each level owns a vector of individual sources. A status word carries one bit per level and shows which levels have any source pending. Commands post or clear a single (level, index) source, and a separate strobe wipes every level at once. Post and clear commands are always accepted in the cycle they are presented, so the command pins have no back-pressure.

The block combines the level status with a software request word, and the two live in one priority space. A software bit `i` inside the software window `[SW_MIN, SW_MAX)` maps to priority `i - SW_MIN + 1`. An external level `i` inside the external window `[EXT_MIN, EXT_MAX)` maps to priority `i`, and any active external level overrides the software result. The block then drives a winning priority and a summary mask. It raises an interrupt request only when the winning priority is strictly above the core's current priority, the two low program-counter bits are zero, and no asynchronous-trap request is present.

When the core accepts the request, the winning priority and summary are held and marked pending. A later update strobe moves them into the summary and ID output registers.

Top module: `irq_level_ctrl`

## Requirements
- R1: A valid post with level < NUM_LEVELS and index < SRC_W sets that source bit and, from the next cycle, sets `level_status[level]`.
- R2: A valid in-range clear drops that source bit. `level_status[level]` falls on the next cycle only if no source of that level remains set, and otherwise stays 1.
- R3: `clr_all` zeroes every source vector and the whole status word on the next cycle. A post or clear in the same cycle is discarded.
- R4: Software priority is `(i - SW_MIN) + 1` for the highest set `sw_req[i]` with SW_MIN <= i < SW_MAX, and 0 if there is none. Software bits outside the window add no priority.
- R5: If any `level_status[i]` with EXT_MIN <= i < EXT_MAX is set, `win_prio` is the highest such `i` and overrides the software priority. Otherwise `win_prio` is the software priority. Status bits below EXT_MIN add no priority.
- R6: `win_summary` bit `i` is set for every set `sw_req[i]` inside the software window and every set `level_status[i]` inside the external window, and is 0 elsewhere.
- R7: `irq_req` is 1 only when (`level_status` or `sw_req` is nonzero), `win_prio` is nonzero and `win_prio` > `cur_ipl`. An equal priority does not interrupt.
- R8: `irq_req` is 0 whenever `pc_low` is not 2'b00.
- R9: When `async_trap_req` is nonzero, `trap_err` is 1 and `irq_req` is 0.
- R10: `take` while `irq_req` is 1 captures `win_prio` and `win_summary` and sets `info_pending` on the next cycle. `update` while `info_pending` is 1 copies the captured values into `intid_out` and `isr_out` and clears `info_pending`, unless a new capture happens in the same cycle. `take` while `irq_req` is 0 has no effect.
- R11: `update` while `info_pending` is 0 pulses `upd_err` in that same cycle and leaves `isr_out` and `intid_out` unchanged.
- R12: A valid post or clear whose level >= NUM_LEVELS or index >= SRC_W changes no state and pulses `cmd_err` in that same cycle.
- R13: A post and a clear to the same source in the same cycle leave the source set, so the post wins.
- R14: Synchronous active-high `rst` zeroes all vectors, the status word, the pending flag, the captured values and the output registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| post_valid | input | 1 | Post command strobe |
| post_level | input | CMD_W | Level of the post |
| post_index | input | CMD_W | Source index of the post |
| clr_valid | input | 1 | Clear command strobe |
| clr_level | input | CMD_W | Level of the clear |
| clr_index | input | CMD_W | Source index of the clear |
| clr_all | input | 1 | Wipe every level |
| sw_req | input | NUM_LEVELS | Software request word |
| cur_ipl | input | LVL_W | Current core priority |
| pc_low | input | 2 | Two low program-counter bits |
| async_trap_req | input | ASYNC_W | Asynchronous-trap request word (unsupported) |
| take | input | 1 | Core accepts the interrupt |
| update | input | 1 | Copy captured info to the output registers |
| level_status | output | NUM_LEVELS | Per-level pending status |
| win_prio | output | LVL_W | Winning priority |
| win_summary | output | NUM_LEVELS | Summary mask |
| irq_req | output | 1 | Interrupt request |
| trap_err | output | 1 | Unsupported asynchronous trap requested |
| cmd_err | output | 1 | Out-of-range post or clear |
| upd_err | output | 1 | Update without captured info |
| info_pending | output | 1 | Captured info awaits an update |
| isr_out | output | NUM_LEVELS | Interrupt summary register |
| intid_out | output | LVL_W | Interrupt ID register |

## Verification
The bench targets a level that keeps a second source after its first one is cleared. A design that drops the status bit on any clear would lose that pending level. It also covers a post colliding with a clear on the same source, where a wrong order silently loses the request. It puts an active external level above a higher software bit, where a design with the scans in the wrong order reports the software priority. It covers a current priority equal to the winner, where an off-by-one comparison interrupts. It also checks that status bits inside the software window never count as external priority, that out-of-range commands and stray updates change nothing, and that misaligned PCs and asynchronous-trap requests suppress delivery.

// File: rtl/irq_lvl_pkg.sv
package irq_lvl_pkg;
  // width of the level and index fields of a command
  localparam int CMD_W = 8;

  typedef struct packed {
    logic             valid;
    logic [CMD_W-1:0] level;
    logic [CMD_W-1:0] index;
  } irq_cmd_t;
endpackage

// File: rtl/irq_level_bank.sv
// Per-level source vectors plus the status word.
module irq_level_bank
  import irq_lvl_pkg::*;
#(
  parameter int NUM_LEVELS = 32,
  parameter int SRC_W      = 64
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wipe,
  input  irq_cmd_t              post,
  input  irq_cmd_t              clr,
  output logic [NUM_LEVELS-1:0] status,
  output logic                  bad_cmd
);
  localparam int IDX_W = $clog2(SRC_W);

  logic post_ok, clr_ok;
  logic [SRC_W-1:0] post_bit, clr_bit;

  always_comb begin
    post_ok  = post.valid && (int'(post.level) < NUM_LEVELS) && (int'(post.index) < SRC_W);
    clr_ok   = clr.valid  && (int'(clr.level)  < NUM_LEVELS) && (int'(clr.index)  < SRC_W);
    bad_cmd  = (post.valid && !post_ok) || (clr.valid && !clr_ok);
    post_bit = {{(SRC_W-1){1'b0}}, 1'b1} << post.index[IDX_W-1:0];
    clr_bit  = {{(SRC_W-1){1'b0}}, 1'b1} << clr.index[IDX_W-1:0];
  end

  for (genvar l = 0; l < NUM_LEVELS; l++) begin : g_lvl
    logic [SRC_W-1:0] vec_q, vec_d;
    logic             stat_q, stat_d;
    logic             post_hit, clr_hit;

    always_comb begin
      post_hit = post_ok && (int'(post.level) == l);
      clr_hit  = clr_ok  && (int'(clr.level)  == l);
      vec_d    = vec_q;
      if (clr_hit)  vec_d = vec_d & ~clr_bit;
      if (post_hit) vec_d = vec_d | post_bit;   // post applied last: it wins
      stat_d = stat_q;
      if (post_hit)                          stat_d = 1'b1;
      else if (clr_hit && (vec_d == '0))     stat_d = 1'b0;
    end

    always_ff @(posedge clk) begin
      if (rst || wipe) begin
        vec_q  <= '0;
        stat_q <= 1'b0;
      end else begin
        vec_q  <= vec_d;
        stat_q <= stat_d;
      end
    end

    assign status[l] = stat_q;
  end
endmodule

// File: rtl/irq_prio_resolve.sv
// Merges software and external requests into one priority and summary.
module irq_prio_resolve #(
  parameter int NUM_LEVELS = 32,
  parameter int SW_MIN     = 1,
  parameter int SW_MAX     = 16,
  parameter int EXT_MIN    = 16,
  parameter int EXT_MAX    = 32,
  localparam int LVL_W     = $clog2(NUM_LEVELS)
) (
  input  logic [NUM_LEVELS-1:0] status,
  input  logic [NUM_LEVELS-1:0] sw_req,
  output logic [LVL_W-1:0]      prio,
  output logic [NUM_LEVELS-1:0] summary
);
  logic [LVL_W-1:0] sw_p, ext_p;
  logic             ext_any;

  always_comb begin
    sw_p    = '0;
    ext_p   = '0;
    ext_any = 1'b0;
    summary = '0;
    for (int i = 0; i < NUM_LEVELS; i++) begin
      if (i >= SW_MIN && i < SW_MAX && sw_req[i]) begin
        sw_p       = LVL_W'(i - SW_MIN + 1);
        summary[i] = 1'b1;
      end
    end
    for (int i = 0; i < NUM_LEVELS; i++) begin
      if (i >= EXT_MIN && i < EXT_MAX && status[i]) begin
        ext_p      = LVL_W'(i);
        ext_any    = 1'b1;
        summary[i] = 1'b1;
      end
    end
    prio = ext_any ? ext_p : sw_p;
  end
endmodule

// File: rtl/irq_info_latch.sv
// Holds the accepted priority/summary until the update strobe.
module irq_info_latch #(
  parameter int NUM_LEVELS = 32,
  localparam int LVL_W     = $clog2(NUM_LEVELS)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  capture,
  input  logic                  update,
  input  logic [LVL_W-1:0]      prio,
  input  logic [NUM_LEVELS-1:0] summary,
  output logic                  pending,
  output logic                  upd_err,
  output logic [NUM_LEVELS-1:0] isr_q,
  output logic [LVL_W-1:0]      id_q
);
  logic [LVL_W-1:0]      cap_prio;
  logic [NUM_LEVELS-1:0] cap_sum;

  assign upd_err = update && !pending;

  always_ff @(posedge clk) begin
    if (rst) begin
      pending  <= 1'b0;
      cap_prio <= '0;
      cap_sum  <= '0;
      isr_q    <= '0;
      id_q     <= '0;
    end else begin
      if (update && pending) begin
        isr_q <= cap_sum;
        id_q  <= cap_prio;
      end
      if (capture) begin
        cap_prio <= prio;
        cap_sum  <= summary;
      end
      pending <= capture || (pending && !update);
    end
  end
endmodule

// File: rtl/irq_level_ctrl.sv
module irq_level_ctrl
  import irq_lvl_pkg::*;
#(
  parameter int NUM_LEVELS = 32,
  parameter int SRC_W      = 64,
  parameter int SW_MIN     = 1,
  parameter int SW_MAX     = 16,
  parameter int EXT_MIN    = 16,
  parameter int EXT_MAX    = 32,
  parameter int ASYNC_W    = 4,
  localparam int LVL_W     = $clog2(NUM_LEVELS)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  post_valid,
  input  logic [CMD_W-1:0]      post_level,
  input  logic [CMD_W-1:0]      post_index,
  input  logic                  clr_valid,
  input  logic [CMD_W-1:0]      clr_level,
  input  logic [CMD_W-1:0]      clr_index,
  input  logic                  clr_all,
  input  logic [NUM_LEVELS-1:0] sw_req,
  input  logic [LVL_W-1:0]      cur_ipl,
  input  logic [1:0]            pc_low,
  input  logic [ASYNC_W-1:0]    async_trap_req,
  input  logic                  take,
  input  logic                  update,
  output logic [NUM_LEVELS-1:0] level_status,
  output logic [LVL_W-1:0]      win_prio,
  output logic [NUM_LEVELS-1:0] win_summary,
  output logic                  irq_req,
  output logic                  trap_err,
  output logic                  cmd_err,
  output logic                  upd_err,
  output logic                  info_pending,
  output logic [NUM_LEVELS-1:0] isr_out,
  output logic [LVL_W-1:0]      intid_out
);
  irq_cmd_t post_cmd, clr_cmd;
  logic     anything, aligned;

  assign post_cmd = '{valid: post_valid, level: post_level, index: post_index};
  assign clr_cmd  = '{valid: clr_valid,  level: clr_level,  index: clr_index};

  irq_level_bank #(.NUM_LEVELS(NUM_LEVELS), .SRC_W(SRC_W)) u_bank (
    .clk     (clk),
    .rst     (rst),
    .wipe    (clr_all),
    .post    (post_cmd),
    .clr     (clr_cmd),
    .status  (level_status),
    .bad_cmd (cmd_err)
  );

  irq_prio_resolve #(
    .NUM_LEVELS(NUM_LEVELS), .SW_MIN(SW_MIN), .SW_MAX(SW_MAX),
    .EXT_MIN(EXT_MIN), .EXT_MAX(EXT_MAX)
  ) u_resolve (
    .status  (level_status),
    .sw_req  (sw_req),
    .prio    (win_prio),
    .summary (win_summary)
  );

  always_comb begin
    anything = (level_status != '0) || (sw_req != '0);
    aligned  = (pc_low == 2'b00);
    trap_err = (async_trap_req != '0);
    irq_req  = anything && aligned && !trap_err &&
               (win_prio != '0) && (win_prio > cur_ipl);
  end

  irq_info_latch #(.NUM_LEVELS(NUM_LEVELS)) u_info (
    .clk     (clk),
    .rst     (rst),
    .capture (take && irq_req),
    .update  (update),
    .prio    (win_prio),
    .summary (win_summary),
    .pending (info_pending),
    .upd_err (upd_err),
    .isr_q   (isr_out),
    .id_q    (intid_out)
  );
endmodule

// File: rtl/irq_level_ctrl_chk.sv
module irq_level_ctrl_chk
  import irq_lvl_pkg::*;
#(
  parameter int NUM_LEVELS = 32,
  parameter int SRC_W      = 64,
  parameter int ASYNC_W    = 4,
  localparam int LVL_W     = $clog2(NUM_LEVELS)
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  post_valid,
  input logic [CMD_W-1:0]      post_level,
  input logic [CMD_W-1:0]      post_index,
  input logic                  clr_valid,
  input logic [CMD_W-1:0]      clr_level,
  input logic [CMD_W-1:0]      clr_index,
  input logic                  clr_all,
  input logic [LVL_W-1:0]      cur_ipl,
  input logic [1:0]            pc_low,
  input logic [ASYNC_W-1:0]    async_trap_req,
  input logic                  take,
  input logic                  update,
  input logic [NUM_LEVELS-1:0] level_status,
  input logic [LVL_W-1:0]      win_prio,
  input logic                  irq_req,
  input logic                  trap_err,
  input logic                  info_pending
);
  logic post_in, clr_same;
  assign post_in  = post_valid && (int'(post_level) < NUM_LEVELS) && (int'(post_index) < SRC_W);
  assign clr_same = clr_valid && (clr_level == post_level) && (clr_index == post_index);

  AST_POST_SETS_STATUS: assert property (@(posedge clk) disable iff (rst)
    post_in && !clr_all |=> level_status[$past(post_level[LVL_W-1:0])]); // R1

  AST_WIPE_CLEARS: assert property (@(posedge clk) disable iff (rst)
    clr_all |=> level_status == '0); // R3

  AST_IRQ_ABOVE_IPL: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> win_prio > cur_ipl); // R7

  AST_NO_IRQ_MISALIGNED: assert property (@(posedge clk) disable iff (rst)
    pc_low != 2'b00 |-> !irq_req); // R8

  AST_TRAP_BLOCKS_IRQ: assert property (@(posedge clk) disable iff (rst)
    async_trap_req != '0 |-> trap_err && !irq_req); // R9

  AST_UPDATE_DRAINS: assert property (@(posedge clk) disable iff (rst)
    update && !(take && irq_req) |=> !info_pending); // R10

  AST_BAD_LEVEL_INERT: assert property (@(posedge clk) disable iff (rst)
    post_valid && int'(post_level) >= NUM_LEVELS && !clr_valid && !clr_all
    |=> $stable(level_status)); // R12

  AST_POST_BEATS_CLEAR: assert property (@(posedge clk) disable iff (rst)
    post_in && clr_same && !clr_all |=> level_status[$past(post_level[LVL_W-1:0])]); // R13
endmodule

bind irq_level_ctrl irq_level_ctrl_chk #(
  .NUM_LEVELS(NUM_LEVELS), .SRC_W(SRC_W), .ASYNC_W(ASYNC_W)
) u_chk (.*);

// File: tb/tb_irq_level_ctrl.sv
`timescale 1ns/1ps
module tb_irq_level_ctrl;
  localparam int NL = 32, SW = 64, LW = 5;
  localparam int SWMIN = 1, SWMAX = 16, EXMIN = 16, EXMAX = 32;

  logic clk = 1'b0, rst = 1'b1;
  always #10 clk = ~clk; // 50 MHz

  logic          post_valid = 0, clr_valid = 0, clr_all = 0, take = 0, update = 0;
  logic [7:0]    post_level = 0, post_index = 0, clr_level = 0, clr_index = 0;
  logic [NL-1:0] sw_req = 0;
  logic [LW-1:0] cur_ipl = 0;
  logic [1:0]    pc_low = 0;
  logic [3:0]    async_trap_req = 0;
  logic [NL-1:0] level_status, win_summary, isr_out;
  logic [LW-1:0] win_prio, intid_out;
  logic irq_req, trap_err, cmd_err, upd_err, info_pending;

  irq_level_ctrl dut (.*);

  int n_tests = 0, n_fail = 0;
  bit done = 0;

  // reference model state
  logic [SW-1:0] m_vec [NL];
  logic [NL-1:0] m_stat = '0, m_lsum = '0, m_isr = '0;
  logic [LW-1:0] m_lprio = '0, m_id = '0;
  logic          m_pend = 0;

  function automatic logic [LW-1:0] f_prio(logic [NL-1:0] st, logic [NL-1:0] s);
    for (int i = EXMAX - 1; i >= EXMIN; i--) if (st[i]) return LW'(i);
    for (int i = SWMAX - 1; i >= SWMIN; i--) if (s[i]) return LW'(i - SWMIN + 1);
    return '0;
  endfunction

  function automatic logic [NL-1:0] f_sum(logic [NL-1:0] st, logic [NL-1:0] s);
    logic [NL-1:0] r = '0;
    for (int i = 0; i < NL; i++) begin
      if (i >= SWMIN && i < SWMAX) r[i] = s[i];
      if (i >= EXMIN && i < EXMAX) r[i] = st[i];
    end
    return r;
  endfunction

  function automatic logic f_irq(logic [NL-1:0] st, logic [NL-1:0] s, logic [LW-1:0] ipl,
                                 logic [1:0] pc, logic [3:0] ast);
    logic [LW-1:0] p = f_prio(st, s);
    return (st != 0 || s != 0) && pc == 0 && ast == 0 && p != 0 && p > ipl;
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    post_valid = 0; clr_valid = 0; clr_all = 0; take = 0; update = 0;
  endtask

  // inputs set at negedge; checks combinational, clocks, updates model, checks state
  task automatic run_cycle();
    logic e_irq, p_ok, c_ok;
    #1;
    e_irq = f_irq(m_stat, sw_req, cur_ipl, pc_low, async_trap_req);
    chk("R4 R5 win_prio", win_prio, f_prio(m_stat, sw_req));
    chk("R6 win_summary", win_summary, f_sum(m_stat, sw_req));
    chk("R7 R8 R9 irq_req", irq_req, e_irq);
    chk("R9 trap_err", trap_err, async_trap_req != 0);
    p_ok = post_valid && post_level < NL && post_index < SW;
    c_ok = clr_valid && clr_level < NL && clr_index < SW;
    chk("R12 cmd_err", cmd_err, (post_valid && !p_ok) || (clr_valid && !c_ok));
    chk("R11 upd_err", upd_err, update && !m_pend);
    @(posedge clk);
    if (update && m_pend) begin m_isr = m_lsum; m_id = m_lprio; end
    if (take && e_irq) begin m_lsum = f_sum(m_stat, sw_req); m_lprio = f_prio(m_stat, sw_req); end
    m_pend = (take && e_irq) || (m_pend && !update);
    if (clr_all) begin
      for (int l = 0; l < NL; l++) m_vec[l] = '0;
      m_stat = '0;
    end else begin
      if (c_ok) begin
        m_vec[clr_level][clr_index] = 1'b0;
        if (m_vec[clr_level] == 0) m_stat[clr_level] = 1'b0;
      end
      if (p_ok) begin
        m_vec[post_level][post_index] = 1'b1;
        m_stat[post_level] = 1'b1;
      end
    end
    @(negedge clk);
    chk("R1 R2 R3 R12 R13 level_status", level_status, m_stat);
    chk("R10 info_pending", info_pending, m_pend);
    chk("R10 R11 isr_out", isr_out, m_isr);
    chk("R10 R11 intid_out", intid_out, m_id);
  endtask

  task automatic do_post(int l, int i);
    idle(); post_valid = 1; post_level = 8'(l); post_index = 8'(i); run_cycle(); idle();
  endtask
  task automatic do_clr(int l, int i);
    idle(); clr_valid = 1; clr_level = 8'(l); clr_index = 8'(i); run_cycle(); idle();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1234_5678));
    for (int l = 0; l < NL; l++) m_vec[l] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R14: reset values, taken while reset is still asserted
    chk("R14 status after reset", level_status, 0);
    chk("R14 pending after reset", info_pending, 0);
    chk("R14 isr after reset", isr_out, 0);
    chk("R14 id after reset", intid_out, 0);
    chk("R14 irq after reset", irq_req, 0);
    rst = 0;

    // software-window level posted: status set, but no priority from it
    do_post(3, 5);
    chk("R5 low level status gives no prio", win_prio, 0);
    chk("R7 no irq from low status", irq_req, 0);
    // partial clear keeps the level pending
    do_post(20, 1); do_post(20, 2); do_clr(20, 1);
    chk("R2 level stays with one source left", level_status[20], 1);
    do_clr(20, 2);
    chk("R2 level drops when empty", level_status[20], 0);
    // external beats a higher software bit; equal ipl does not interrupt
    sw_req = 32'h0000_8000; cur_ipl = 0; run_cycle();
    chk("R4 sw bit 15 -> prio 15", win_prio, 15);
    do_post(16, 0);
    chk("R5 external 16 overrides software 15", win_prio, 16);
    cur_ipl = 16; run_cycle();
    chk("R7 equal priority blocked", irq_req, 0);
    cur_ipl = 15; pc_low = 2'b10; run_cycle();
    chk("R8 misaligned pc blocks", irq_req, 0);
    pc_low = 0; async_trap_req = 4'h2; run_cycle();
    chk("R9 trap error raised", trap_err, 1);
    async_trap_req = 0;
    // stray update, then take and update
    update = 1; run_cycle(); idle();
    chk("R11 stray update keeps id", intid_out, 0);
    take = 1; run_cycle(); idle();
    chk("R10 pending after take", info_pending, 1);
    update = 1; run_cycle(); idle();
    chk("R10 id copied", intid_out, 16);
    chk("R10 summary copied", isr_out, 32'h0001_8000);
    // collision: post wins
    post_valid = 1; post_level = 25; post_index = 7;
    clr_valid = 1; clr_level = 25; clr_index = 7; run_cycle(); idle();
    chk("R13 post wins over clear", level_status[25], 1);
    // out-of-range commands
    post_valid = 1; post_level = 40; post_index = 0; run_cycle(); idle();
    post_valid = 1; post_level = 2; post_index = 70; run_cycle(); idle();
    chk("R12 out-of-range ignored", level_status[2], 0);
    clr_all = 1; run_cycle(); idle();
    chk("R3 clear-all wipes", level_status, 0);

    // constrained random
    for (int n = 0; n < 4000; n++) begin
      post_valid = ($urandom % 3) == 0;
      post_level = 8'((($urandom % 10) == 0) ? 32 + $urandom % 8 : $urandom % NL);
      post_index = 8'((($urandom % 10) == 0) ? 64 + $urandom % 4 : $urandom % 4);
      clr_valid  = ($urandom % 3) == 0;
      clr_level  = (($urandom % 2) == 0) ? post_level : 8'($urandom % NL);
      clr_index  = 8'($urandom % 4);
      clr_all    = ($urandom % 60) == 0;
      sw_req     = $urandom & $urandom & $urandom;
      cur_ipl    = LW'($urandom);
      pc_low     = (($urandom % 8) == 0) ? 2'($urandom) : 2'b00;
      async_trap_req = (($urandom % 20) == 0) ? 4'($urandom) : 4'h0;
      take       = ($urandom % 3) == 0;
      update     = ($urandom % 4) == 0;
      run_cycle();
    end
    idle();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule